// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table held in a word-addressed memory. A request carries the virtual address, a write flag and a root pointer to the first-level directory. The walker reads the directory entry that the top ten address bits select. That entry names the second-level table, and the walker then reads the entry picked by the middle ten bits. The frame number in that second entry is joined to the 12-bit page offset to form the result.

Table entries are 32 bits wide:

| Bits | Meaning |
|------|---------|
| [31:12] | Frame number, or base of the next table |
| [0] | Present |
| [1] | Writable |
| [11:2] | Ignored |

A missing entry at either level ends the walk at once with a fault. A write that reaches a second-level entry without write permission also ends with a fault. The memory port uses a one-cycle read strobe and a response valid that may arrive any number of cycles later (at least one). Only one read is in flight at a time, and a new translation is taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1 and mem_req and resp_valid are 0.
- R2: The first read goes to word address {req_root[31:12], va[31:22]}. req_root[11:0] is ignored. For va 0x00403004 the low ten bits of that address are 1.
- R3: The second read goes to word address {outer_entry[31:12], va[21:12]}. For va 0x00403004 the low ten bits of that address are 3.
- R4: A successful walk returns resp_fault=0, resp_cause=0 and resp_paddr={inner_entry[31:12], va[11:0]}. For va 0x00403004 the offset field is 4.
- R5: An outer entry with bit 0 (present) clear ends the walk with resp_fault=1, resp_cause=1 and resp_paddr=0, and no second read is made.
- R6: An inner entry with bit 0 clear gives resp_fault=1, resp_cause=2 and resp_paddr=0.
- R7: A write request whose inner entry has bit 1 (writable) clear gives resp_fault=1 and resp_cause=3. A read of the same entry, or a write when bit 1 is set, succeeds.
- R8: Each read is a single-cycle mem_req pulse. No further pulse is made until mem_valid answers it, and mem_addr holds steady while the read is outstanding.
- R9: req_valid is ignored while req_ready is 0. A request raised during a walk neither changes its result nor starts another walk.
- R10: resp_valid is a one-cycle pulse, and req_ready is 1 in the following cycle.
- R11: The result does not depend on memory latency. Latencies of 1 to 8 cycles give the same answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_root | input | 32 | Byte address of the first-level directory |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 30 | Word address of the entry being read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_cause | output | 2 | 0 ok, 1 outer missing, 2 inner missing, 3 write denied |
| resp_paddr | output | 32 | Translated address, 0 on a fault |

## Verification
The bench aims at the missing first-level entry. A walker that ignored it would issue a stray second read from a garbage table base, which shows up as an extra read or a wrong cause. It checks a write to a read-only page against a read of the same page. Swapping or dropping the permission test would deny the read or allow the write. It also varies the memory latency and raises a request in the middle of a walk. A design that consumed data before it was valid, re-issued its strobe, or latched the intruding request would return a wrong address or start a phantom walk. The address 0x00403004 and the all-ones address check that the index fields are cut at the right bit positions.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_OUTER = 3'd1,
    ST_RD_INNER = 3'd2,
    ST_DONE     = 3'd3,
    ST_FAULT    = 3'd4
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_OUTER = 2'd1,
    CAUSE_INNER = 2'd2,
    CAUSE_PROT  = 2'd3
  } walk_cause_e;

  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_WRITE_BIT   = 1;

endpackage

// File: rtl/pt_rst_sync.sv
module pt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;

  // Assert asynchronously, release on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end

endmodule

// File: rtl/pt_va_fields.sv
module pt_va_fields #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic [VA_W-1:0]                 vaddr,
  output logic [(VA_W-OFF_W)/2-1:0]       idx_outer,
  output logic [(VA_W-OFF_W)/2-1:0]       idx_inner,
  output logic [OFF_W-1:0]                offset
);

  localparam int IDX_W = (VA_W - OFF_W) / 2;

  // Top field picks the directory slot, middle field the table slot.
  assign idx_outer = vaddr[VA_W-1 -: IDX_W];
  assign idx_inner = vaddr[OFF_W +: IDX_W];
  assign offset    = vaddr[OFF_W-1:0];

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic [VA_W-1:0]       entry,
  input  logic                  is_write,
  output logic [VA_W-OFF_W-1:0] frame,
  output logic                  present,
  output logic                  perm_ok
);

  logic writable;
  logic unused_entry_bits;

  assign frame    = entry[VA_W-1:OFF_W];
  assign present  = entry[PTE_PRESENT_BIT];
  assign writable = entry[PTE_WRITE_BIT];
  assign perm_ok  = !is_write || writable;

  assign unused_entry_bits = ^entry[OFF_W-1:PTE_WRITE_BIT+1];

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_valid,
  input  logic        present,
  input  logic        perm_ok,
  output walk_state_e state,
  output logic        req_ready,
  output logic        mem_req,
  output logic        waiting,
  output logic        load_req,
  output logic        load_table,
  output logic        load_frame,
  output walk_cause_e cause
);

  walk_state_e state_n;
  walk_cause_e cause_n;
  logic        waiting_n;
  logic        reading;
  logic        take;

  assign reading   = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
  assign mem_req   = reading && !waiting;
  assign take      = waiting && mem_valid;
  assign req_ready = (state == ST_IDLE);
  assign load_req  = req_ready && req_valid;

  assign load_table = (state == ST_RD_OUTER) && take && present;
  assign load_frame = (state == ST_RD_INNER) && take && present && perm_ok;

  always_comb begin
    state_n = state;
    cause_n = cause;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          state_n = ST_RD_OUTER;
          cause_n = CAUSE_NONE;
        end
      end
      ST_RD_OUTER: begin
        if (take) begin
          if (!present) begin
            state_n = ST_FAULT;
            cause_n = CAUSE_OUTER;
          end else begin
            state_n = ST_RD_INNER;
          end
        end
      end
      ST_RD_INNER: begin
        if (take) begin
          if (!present) begin
            state_n = ST_FAULT;
            cause_n = CAUSE_INNER;
          end else if (!perm_ok) begin
            state_n = ST_FAULT;
            cause_n = CAUSE_PROT;
          end else begin
            state_n = ST_DONE;
          end
        end
      end
      ST_DONE:  state_n = ST_IDLE;
      ST_FAULT: state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    waiting_n = waiting;
    if (mem_req) begin
      waiting_n = 1'b1;
    end else if (mem_valid) begin
      waiting_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cause   <= CAUSE_NONE;
      waiting <= 1'b0;
    end else begin
      state   <= state_n;
      cause   <= cause_n;
      waiting <= waiting_n;
    end
  end

  // R8: a strobe is never repeated in the next cycle.
  a_r8_single_strobe : assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R9: no request is taken while a read is being issued.
  a_r9_busy_not_ready : assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       req_valid,
  output logic                                       req_ready,
  input  logic [VA_W-1:0]                            req_vaddr,
  input  logic                                       req_write,
  input  logic [VA_W-1:0]                            req_root,
  output logic                                       mem_req,
  output logic [VA_W-OFF_W+(VA_W-OFF_W)/2-1:0]       mem_addr,
  input  logic                                       mem_valid,
  input  logic [VA_W-1:0]                            mem_rdata,
  output logic                                       resp_valid,
  output logic                                       resp_fault,
  output logic [1:0]                                 resp_cause,
  output logic [VA_W-1:0]                            resp_paddr
);

  localparam int FRAME_W = VA_W - OFF_W;
  localparam int IDX_W   = FRAME_W / 2;

  logic rst_n_s;

  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] table_q;
  logic [VA_W-1:0]    paddr_q;

  logic [IDX_W-1:0]   idx_outer;
  logic [IDX_W-1:0]   idx_inner;
  logic [OFF_W-1:0]   offset;
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_present;
  logic               ent_perm_ok;

  walk_state_e state;
  walk_cause_e cause;
  logic        waiting;
  logic        load_req;
  logic        load_table;
  logic        load_frame;
  logic        unused_root_low;

  assign unused_root_low = ^req_root[OFF_W-1:0];

  pt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pt_va_fields #(.VA_W(VA_W), .OFF_W(OFF_W)) u_fields (
    .vaddr     (va_q),
    .idx_outer (idx_outer),
    .idx_inner (idx_inner),
    .offset    (offset)
  );

  pt_entry_decode #(.VA_W(VA_W), .OFF_W(OFF_W)) u_decode (
    .entry    (mem_rdata),
    .is_write (wr_q),
    .frame    (ent_frame),
    .present  (ent_present),
    .perm_ok  (ent_perm_ok)
  );

  pt_walk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .mem_valid  (mem_valid),
    .present    (ent_present),
    .perm_ok    (ent_perm_ok),
    .state      (state),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .waiting    (waiting),
    .load_req   (load_req),
    .load_table (load_table),
    .load_frame (load_frame),
    .cause      (cause)
  );

  // Request capture, enabled on acceptance only.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      va_q   <= '0;
      wr_q   <= 1'b0;
      root_q <= '0;
    end else if (load_req) begin
      va_q   <= req_vaddr;
      wr_q   <= req_write;
      root_q <= req_root[VA_W-1:OFF_W];
    end
  end

  // Second-level table base from the directory entry.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      table_q <= '0;
    end else if (load_table) begin
      table_q <= ent_frame;
    end
  end

  // Result address: cleared at acceptance so faults report zero.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      paddr_q <= '0;
    end else if (load_req) begin
      paddr_q <= '0;
    end else if (load_frame) begin
      paddr_q <= {ent_frame, offset};
    end
  end

  assign mem_addr   = (state == ST_RD_INNER) ? {table_q, idx_inner}
                                             : {root_q, idx_outer};
  assign resp_valid = (state == ST_DONE) || (state == ST_FAULT);
  assign resp_fault = (state == ST_FAULT);
  assign resp_cause = cause;
  assign resp_paddr = paddr_q;

  // R8: the read address stays put until the memory answers.
  a_r8_addr_hold : assert property (@(posedge clk) disable iff (!rst_n_s)
    (waiting && !mem_valid) |=> $stable(mem_addr));

  // R10: the result is a single-cycle pulse followed by readiness.
  a_r10_resp_pulse : assert property (@(posedge clk) disable iff (!rst_n_s)
    resp_valid |=> (!resp_valid && req_ready));

  // R5: a faulted walk reports no translated address.
  a_r5_fault_zero_addr : assert property (@(posedge clk) disable iff (!rst_n_s)
    (resp_valid && resp_fault) |-> (resp_paddr == '0));

  // R4: a successful result never carries a fault cause.
  a_r4_ok_no_cause : assert property (@(posedge clk) disable iff (!rst_n_s)
    (resp_valid && !resp_fault) |-> (resp_cause == 2'd0));

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic [31:0] req_root;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_rdata;
  logic        resp_valid;
  logic        resp_fault;
  logic [1:0]  resp_cause;
  logic [31:0] resp_paddr;

  int n_checks;
  int n_fail;
  int lat_cfg;
  int rd_cnt;
  logic [29:0] rd_log [0:7];
  logic [31:0] mem [logic [29:0]];

  pt_walker uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .req_root   (req_root),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_rdata  (mem_rdata),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_cause (resp_cause),
    .resp_paddr (resp_paddr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] rd_word(logic [29:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Behavioural memory: one strobe, answered after lat_cfg cycles.
  initial begin
    mem_valid = 1'b0;
    mem_rdata = 32'h0;
    rd_cnt    = 0;
    @(negedge clk);
    forever begin
      if (mem_req === 1'b1) begin
        logic [29:0] a;
        a = mem_addr;
        if (rd_cnt < 8) rd_log[rd_cnt] = a;
        rd_cnt++;
        repeat (lat_cfg) @(negedge clk);
        mem_rdata = rd_word(a);
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  // Reference model of the walk.
  task automatic model(input logic [31:0] va, input logic wr, input logic [31:0] root,
                       output int nrd, output logic [29:0] a1, output logic [29:0] a2,
                       output logic [1:0] cause, output logic [31:0] pa);
    logic [31:0] e1, e2;
    a1 = {root[31:12], va[31:22]};
    e1 = rd_word(a1);
    a2 = {e1[31:12], va[21:12]};
    pa = 32'h0;
    if (!e1[0]) begin
      nrd = 1; cause = 2'd1;
    end else begin
      nrd = 2;
      e2 = rd_word(a2);
      if (!e2[0])              cause = 2'd2;
      else if (wr && !e2[1])   cause = 2'd3;
      else begin cause = 2'd0; pa = {e2[31:12], va[11:0]}; end
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input logic [31:0] root,
                      input int lat, input bit busy_poke, input string tag);
    int nrd; logic [29:0] a1, a2; logic [1:0] ec; logic [31:0] ep;
    int t;
    model(va, wr, root, nrd, a1, a2, ec, ep);
    lat_cfg = lat;
    @(negedge clk);
    rd_cnt    = 0;
    req_vaddr = va;
    req_write = wr;
    req_root  = root;
    req_valid = 1'b1;
    @(negedge clk);
    if (busy_poke) begin
      req_vaddr = ~va;
      req_write = ~wr;
      req_root  = ~root;
      @(negedge clk);
    end
    req_valid = 1'b0;
    t = 0;
    while (resp_valid !== 1'b1 && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(resp_valid === 1'b1, "R11", {tag, " response arrived"}, {31'd0, resp_valid}, 32'd1);
    chk(resp_cause === ec, ec == 2'd0 ? "R4" : (ec == 2'd1 ? "R5" : (ec == 2'd2 ? "R6" : "R7")),
        {tag, " cause"}, {30'd0, resp_cause}, {30'd0, ec});
    chk(resp_fault === (ec != 2'd0), "R7", {tag, " fault flag"}, {31'd0, resp_fault},
        {31'd0, ec != 2'd0});
    chk(resp_paddr === ep, "R4", {tag, " paddr"}, resp_paddr, ep);
    chk(rd_cnt == nrd, "R5", {tag, " read count"}, rd_cnt, nrd);
    chk(rd_log[0] === a1, "R2", {tag, " outer address"}, {2'b0, rd_log[0]}, {2'b0, a1});
    if (nrd == 2)
      chk(rd_log[1] === a2, "R3", {tag, " inner address"}, {2'b0, rd_log[1]}, {2'b0, a2});
    @(negedge clk);
    chk(resp_valid === 1'b0 && req_ready === 1'b1, "R10", {tag, " pulse then ready"},
        {30'd0, resp_valid, req_ready}, 32'd1);
    if (busy_poke) begin
      repeat (4) @(negedge clk);
      chk(rd_cnt == nrd && req_ready === 1'b1, "R9", {tag, " no phantom walk"},
          rd_cnt, nrd);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    n_checks  = 0;
    n_fail    = 0;
    lat_cfg   = 1;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_write = 1'b0;
    req_root  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b1 && mem_req === 1'b0 && resp_valid === 1'b0, "R1",
        "reset state", {29'd0, req_ready, mem_req, resp_valid}, 32'h4);

    // Directed: example address, index split check.
    mem[{20'h00010, 10'd1}] = 32'h0002_0001;
    mem[{20'h00020, 10'd3}] = 32'h00AB_C003;
    walk(32'h0040_3004, 1'b0, 32'h0001_0000, 1, 1'b0, "example");
    chk(rd_log[0][9:0] == 10'd1, "R2", "p1 field", {22'd0, rd_log[0][9:0]}, 32'd1);
    chk(rd_log[1][9:0] == 10'd3, "R3", "p2 field", {22'd0, rd_log[1][9:0]}, 32'd3);
    chk(resp_paddr === 32'h00AB_C004, "R4", "example paddr", resp_paddr, 32'h00AB_C004);

    // Root low bits junk must be ignored (R2); slow memory (R11).
    walk(32'h0040_3004, 1'b0, 32'h0001_0ABC, 8, 1'b0, "R2 root junk, R11 slow");

    // Outer entry missing (R5).
    mem[{20'h00010, 10'd2}] = 32'hFFFF_F002;
    walk(32'h0080_0000, 1'b0, 32'h0001_0000, 2, 1'b0, "R5 outer missing");

    // Inner entry missing (R6).
    mem[{20'h00020, 10'd4}] = 32'h1234_5002;
    walk(32'h0040_4010, 1'b0, 32'h0001_0000, 3, 1'b0, "R6 inner missing");

    // Permission cases (R7).
    mem[{20'h00020, 10'd5}] = 32'h5555_5001;
    walk(32'h0040_5ABC, 1'b1, 32'h0001_0000, 1, 1'b0, "R7 write ro");
    walk(32'h0040_5ABC, 1'b0, 32'h0001_0000, 1, 1'b0, "R7 read ro");
    mem[{20'h00020, 10'd6}] = 32'h6666_6003;
    walk(32'h0040_6FFF, 1'b1, 32'h0001_0000, 1, 1'b0, "R7 write rw");

    // Request during a walk (R9).
    walk(32'h0040_3004, 1'b0, 32'h0001_0000, 4, 1'b1, "R9 busy poke");

    // All-ones address.
    mem[{20'hFFFFF, 10'h3FF}] = 32'h0030_0001;
    mem[{20'h00300, 10'h3FF}] = 32'hABCD_E003;
    walk(32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1, 1'b0, "R4 max indices");

    // Random walks.
    for (int i = 0; i < 80; i++) begin
      logic [31:0] va, root, e1, e2;
      logic [9:0]  tb;
      va   = $urandom;
      root = $urandom;
      tb   = 10'($urandom);
      e1 = {10'h2A5, tb, 10'($urandom), 1'b0, ($urandom % 8) != 0};
      e2 = {20'($urandom), 10'($urandom), 1'($urandom), ($urandom % 8) != 0};
      mem[{root[31:12], va[31:22]}] = e1;
      mem[{e1[31:12], va[21:12]}]   = e2;
      walk(va, 1'($urandom), root, 1 + ($urandom % 6), ($urandom % 5) == 0, "R11 random");
    end

    finish_run();
  end

endmodule